// File: doc/BRIEF.md
# CAN Receive Frame Queue with Host Window

This block sits between a CAN protocol engine and a host register interface. Frames arrive fully formed from the engine, one per cycle when a valid strobe is high. Each frame carries a 32-bit identifier word, a length code, eight data bytes and a 16-bit timestamp. The block stores up to four of these frames in arrival order.

The oldest unread frame is always visible to the host on a set of window outputs laid out like a mailbox. The host reads these outputs and then writes a fixed code to a pointer register, which discards that frame and moves the next one into view. A small set of byte-wide registers holds the rest of the host state:

- an enable bit, together with an empty flag;
- a receive interrupt flag, together with its enable;
- a sticky overrun flag.

When a frame arrives and all four entries are in use, that frame is dropped and the overrun flag is raised.

Top module: `canrx_fifo_window`

## Requirements
- R1: After reset, `ctrl_rd` reads 0x80 (disabled, empty), and `istat_rd`, `ien_rd` and `err_rd` read 0. `irq` is low.
- R2: The window shows the oldest stored frame unchanged. `win_id` holds the identifier word: bit 31 is the extended flag, bit 30 is the remote flag, a standard ID sits in bits 28:18 and an extended ID in bits 28:0. `win_len` carries the length code in bits 3:0, with bits 7:4 at zero. `win_data` holds byte k in bits 8k+7:8k. `win_stamp_hi` and `win_stamp_lo` are the upper and lower timestamp bytes.
- R3: Frames leave in arrival order. The queue holds up to 4 frames and wraps around correctly. The window changes one cycle after a pop and only because of a pop, while the queue stays enabled and non-empty.
- R4: Writing 0xFF to register address 1 pops the head frame. Any other value written there has no effect.
- R5: Bit 7 of the control register (address 0) reads 1 exactly when no unread frame remains. Bit 0 of that register is the enable.
- R6: A pop write while the queue is empty, or while the queue is disabled, is ignored.
- R7: While the enable is 0, incoming frames are discarded. Writing 0 to the enable empties the queue at the next clock edge.
- R8: A frame that arrives while 4 frames are stored is discarded, and the stored frames are kept. Bit 5 of the error register (address 4) is then set. That bit stays set until it is written with 0.
- R9: Bit 4 of the interrupt status register (address 2) is set each time a frame is stored. Writing 0 to that bit clears it, and writing 1 has no effect. A store in the same cycle as a clear leaves the bit set.
- R10: `irq` is high exactly when status bit 4 and bit 4 of the interrupt enable register (address 3) are both 1.
- R11: The number of stored frames never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | Engine presents a frame this cycle |
| frm_id | input | 32 | Identifier word of incoming frame |
| frm_len | input | 4 | Length code of incoming frame |
| frm_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| frm_stamp | input | 16 | Timestamp of incoming frame |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Host register address |
| wr_data | input | 8 | Host register write data |
| win_id | output | 32 | Head frame identifier word |
| win_len | output | 8 | Head frame length byte |
| win_data | output | 64 | Head frame data bytes |
| win_stamp_hi | output | 8 | Head frame timestamp upper byte |
| win_stamp_lo | output | 8 | Head frame timestamp lower byte |
| ctrl_rd | output | 8 | Control register: enable bit 0, empty bit 7 |
| istat_rd | output | 8 | Interrupt status: receive flag bit 4 |
| ien_rd | output | 8 | Interrupt enable: receive enable bit 4 |
| err_rd | output | 8 | Error register: overrun bit 5 |
| irq | output | 1 | Receive interrupt request |

## Verification
A corrupted read pointer or occupancy count shows up at the ports in one of several ways. The window may present a frame out of order. A popped frame may appear again. The empty flag may disagree with the number of frames pushed and popped. Each of these is visible the cycle after the pop or push that exposes it, so the scoreboard compares every head frame against the arrival order at the moment it is consumed. An overrun that wrongly overwrites a stored entry surfaces when that entry reaches the head. A flush that fails to clear the count shows as a stale head frame appearing right after re-enabling.

// File: rtl/canrx_pkg.sv
package canrx_pkg;
   localparam int ID_W    = 32;
   localparam int LEN_W   = 4;
   localparam int DATA_W  = 64;
   localparam int STAMP_W = 16;

   // host register addresses
   localparam logic [2:0] A_CTRL  = 3'd0;
   localparam logic [2:0] A_PTR   = 3'd1;
   localparam logic [2:0] A_ISTAT = 3'd2;
   localparam logic [2:0] A_IEN   = 3'd3;
   localparam logic [2:0] A_ERR   = 3'd4;

   // bit positions inside the host registers
   localparam int B_EN    = 0;
   localparam int B_EMPTY = 7;
   localparam int B_RXF   = 4;
   localparam int B_OVR   = 5;

   typedef struct packed {
      logic [ID_W-1:0]    id;
      logic [LEN_W-1:0]   len;
      logic [DATA_W-1:0]  data;
      logic [STAMP_W-1:0] stamp;
   } canrx_frame_t;
endpackage

// File: rtl/canrx_store.sv
module canrx_store
   import canrx_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  canrx_frame_t      wr_frame,
   input  logic [PTR_W-1:0]  rd_ptr,
   output canrx_frame_t      rd_frame
);
   canrx_frame_t slot_w [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      canrx_frame_t ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent_q <= '0;
         else if (wr_en && wr_ptr == PTR_W'(i))
            ent_q <= wr_frame;
      end
      assign slot_w[i] = ent_q;
   end

   assign rd_frame = slot_w[rd_ptr];
endmodule

// File: rtl/canrx_ptr.sv
module canrx_ptr #(
   parameter int DEPTH = 4,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             push_req,
   input  logic             pop_req,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [CNT_W-1:0] occ,
   output logic             push_ok,
   output logic             drop
);
   logic full, pop_ok;

   assign full    = (occ == CNT_W'(DEPTH));
   assign push_ok = run && push_req && !full;
   assign drop    = run && push_req && full;
   assign pop_ok  = run && pop_req && (occ != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else if (!run) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         occ <= occ + CNT_W'(push_ok) - CNT_W'(pop_ok);
      end
   end
endmodule

// File: rtl/canrx_flags.sv
module canrx_flags
   import canrx_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter logic [7:0] POP_CODE = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              push_ok,
   input  logic              drop,
   output logic              enable,
   output logic              run,
   output logic              pop_req,
   output logic              rx_flag,
   output logic              rx_ien,
   output logic              ovr_flag
);
   logic ctrl_wr, istat_wr, ien_wr, err_wr;

   assign ctrl_wr  = wr_en && wr_addr == ADDR_W'(A_CTRL);
   assign istat_wr = wr_en && wr_addr == ADDR_W'(A_ISTAT);
   assign ien_wr   = wr_en && wr_addr == ADDR_W'(A_IEN);
   assign err_wr   = wr_en && wr_addr == ADDR_W'(A_ERR);
   assign pop_req  = wr_en && wr_addr == ADDR_W'(A_PTR) && wr_data == POP_CODE;
   // a write that clears the enable flushes in the same edge
   assign run      = enable && !(ctrl_wr && !wr_data[B_EN]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable   <= 1'b0;
         rx_flag  <= 1'b0;
         rx_ien   <= 1'b0;
         ovr_flag <= 1'b0;
      end else begin
         if (ctrl_wr) enable <= wr_data[B_EN];
         if (ien_wr)  rx_ien <= wr_data[B_RXF];
         if (push_ok)
            rx_flag <= 1'b1;
         else if (istat_wr && !wr_data[B_RXF])
            rx_flag <= 1'b0;
         if (drop)
            ovr_flag <= 1'b1;
         else if (err_wr && !wr_data[B_OVR])
            ovr_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/canrx_fifo_window.sv
module canrx_fifo_window
   import canrx_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int ADDR_W = 3,
   parameter logic [7:0] POP_CODE = 8'hFF,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_valid,
   input  logic [31:0]       frm_id,
   input  logic [3:0]        frm_len,
   input  logic [63:0]       frm_data,
   input  logic [15:0]       frm_stamp,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output logic [31:0]       win_id,
   output logic [7:0]        win_len,
   output logic [63:0]       win_data,
   output logic [7:0]        win_stamp_hi,
   output logic [7:0]        win_stamp_lo,
   output logic [7:0]        ctrl_rd,
   output logic [7:0]        istat_rd,
   output logic [7:0]        ien_rd,
   output logic [7:0]        err_rd,
   output logic              irq
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must be at least 3");
   end

   canrx_frame_t     in_frame, head;
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] occ;
   logic push_ok, drop, enable, run, pop_req, rx_flag, rx_ien, ovr_flag;

   assign in_frame = '{id: frm_id, len: frm_len, data: frm_data, stamp: frm_stamp};

   canrx_flags #(.ADDR_W(ADDR_W), .POP_CODE(POP_CODE)) u_flags (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .push_ok, .drop,
      .enable, .run, .pop_req, .rx_flag, .rx_ien, .ovr_flag
   );

   canrx_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk, .rst_n, .run, .push_req(frm_valid), .pop_req,
      .wr_ptr, .rd_ptr, .occ, .push_ok, .drop
   );

   canrx_store #(.DEPTH(DEPTH)) u_store (
      .clk, .rst_n, .wr_en(push_ok), .wr_ptr, .wr_frame(in_frame),
      .rd_ptr, .rd_frame(head)
   );

   assign win_id       = head.id;
   assign win_len      = {4'b0000, head.len};
   assign win_data     = head.data;
   assign win_stamp_hi = head.stamp[15:8];
   assign win_stamp_lo = head.stamp[7:0];

   always_comb begin
      ctrl_rd  = '0;
      istat_rd = '0;
      ien_rd   = '0;
      err_rd   = '0;
      ctrl_rd[B_EN]    = enable;
      ctrl_rd[B_EMPTY] = (occ == '0);
      istat_rd[B_RXF]  = rx_flag;
      ien_rd[B_RXF]    = rx_ien;
      err_rd[B_OVR]    = ovr_flag;
   end

   assign irq = rx_flag && rx_ien;
endmodule

// File: rtl/canrx_fifo_window_chk.sv
module canrx_fifo_window_chk #(
   parameter int DEPTH = 4,
   parameter int ADDR_W = 3,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frm_valid,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:0]        wr_data,
   input logic [7:0]        ctrl_rd,
   input logic [7:0]        istat_rd,
   input logic [7:0]        ien_rd,
   input logic [7:0]        err_rd,
   input logic              irq,
   input logic [31:0]       win_id,
   input logic [CNT_W-1:0]  occ
);
   logic pop_wr, ctrl_wr, istat_wr;
   assign pop_wr   = wr_en && wr_addr == ADDR_W'(1) && wr_data == 8'hFF;
   assign ctrl_wr  = wr_en && wr_addr == ADDR_W'(0);
   assign istat_wr = wr_en && wr_addr == ADDR_W'(2);

   assert_occ_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CNT_W'(DEPTH));

   assert_off_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_rd[0] |-> ctrl_rd[7]);

   assert_head_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rd[0] && !ctrl_rd[7] && !pop_wr && !ctrl_wr) |=> $stable(win_id));

   assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && ctrl_rd[0] && occ == CNT_W'(DEPTH) && !ctrl_wr) |=> err_rd[5]);

   assert_rxflag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && ctrl_rd[0] && occ < CNT_W'(DEPTH) && !ctrl_wr) |=> istat_rd[4]);

   assert_rxflag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (istat_rd[4] && !istat_wr) |=> istat_rd[4]);

   assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (istat_rd[4] && ien_rd[4]));

   assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_wr && ctrl_rd[7] && !frm_valid) |=> ctrl_rd[7]);
endmodule

bind canrx_fifo_window canrx_fifo_window_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .wr_en(wr_en),
   .wr_addr(wr_addr), .wr_data(wr_data), .ctrl_rd(ctrl_rd),
   .istat_rd(istat_rd), .ien_rd(ien_rd), .err_rd(err_rd), .irq(irq),
   .win_id(win_id), .occ(occ)
);

// File: tb/canrx_fifo_window_test.sv
module canrx_fifo_window_test;
   import canrx_pkg::*;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic frm_valid = 1'b0;
   logic [31:0] frm_id = '0;
   logic [3:0]  frm_len = '0;
   logic [63:0] frm_data = '0;
   logic [15:0] frm_stamp = '0;
   logic wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [31:0] win_id;
   logic [7:0]  win_len, win_stamp_hi, win_stamp_lo, ctrl_rd, istat_rd, ien_rd, err_rd;
   logic [63:0] win_data;
   logic irq;

   int total = 0, bad = 0;
   bit finished = 0;
   canrx_frame_t sb[$];
   bit m_en = 0;
   int m_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   canrx_fifo_window uut (.*);

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   function automatic canrx_frame_t mk(logic [31:0] id, logic [3:0] len, logic [7:0] seed);
      canrx_frame_t f;
      f.id = id;
      f.len = len;
      f.data = {8{seed}} ^ 64'h0F1E2D3C4B5A6978;
      f.stamp = {seed, ~seed};
      return f;
   endfunction

   // driver: presents a frame and records it in the scoreboard if it should be stored
   task automatic push_frame(canrx_frame_t f);
      frm_valid = 1'b1; frm_id = f.id; frm_len = f.len;
      frm_data = f.data; frm_stamp = f.stamp;
      @(negedge clk);
      frm_valid = 1'b0;
      if (m_en && m_cnt < 4) begin
         sb.push_back(f);
         m_cnt++;
      end
   endtask

   task automatic host_wr(logic [2:0] a, logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // monitor: compares the head window with the oldest expected frame
   task automatic peek_check(string req);
      canrx_frame_t e;
      if (sb.size() == 0) begin
         total++; bad++;
         $display("FAIL %s scoreboard empty act=0 exp=1", req);
         return;
      end
      e = sb[0];
      chk(req, "win_id", 64'(win_id), 64'(e.id));
      chk(req, "win_len", 64'(win_len), 64'({4'b0, e.len}));
      chk(req, "win_data", win_data, e.data);
      chk(req, "win_stamp_hi", 64'(win_stamp_hi), 64'(e.stamp[15:8]));
      chk(req, "win_stamp_lo", 64'(win_stamp_lo), 64'(e.stamp[7:0]));
   endtask

   task automatic pop_check(string req);
      peek_check(req);
      host_wr(A_PTR, 8'hFF);
      if (sb.size() != 0) begin
         void'(sb.pop_front());
         m_cnt--;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog act=timeout exp=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "ctrl", 64'(ctrl_rd), 64'h80);
      chk("R1", "istat", 64'(istat_rd), 64'h00);
      chk("R1", "ien", 64'(ien_rd), 64'h00);
      chk("R1", "err", 64'(err_rd), 64'h00);
      chk("R1", "irq", 64'(irq), 64'h0);

      // R7 frames ignored while disabled
      push_frame(mk(32'h0ABC_0000, 4'd2, 8'h11));
      chk("R7", "ctrl while off", 64'(ctrl_rd), 64'h80);
      chk("R7", "istat while off", 64'(istat_rd), 64'h00);
      // R6 pop while disabled ignored
      host_wr(A_PTR, 8'hFF);
      chk("R6", "ctrl after pop off", 64'(ctrl_rd), 64'h80);

      host_wr(A_CTRL, 8'h01); m_en = 1;
      chk("R5", "ctrl enabled empty", 64'(ctrl_rd), 64'h81);

      // R2 standard id, full length
      push_frame(mk(32'(11'h123) << 18, 4'd8, 8'hA1));
      chk("R5", "ctrl not empty", 64'(ctrl_rd), 64'h01);
      chk("R9", "rx flag set", 64'(istat_rd), 64'h10);
      chk("R10", "irq masked", 64'(irq), 64'h0);
      peek_check("R2");
      host_wr(A_IEN, 8'h10);
      chk("R10", "irq raised", 64'(irq), 64'h1);
      host_wr(A_ISTAT, 8'hFF);
      chk("R9", "write one keeps", 64'(istat_rd), 64'h10);
      host_wr(A_ISTAT, 8'hEF);
      chk("R9", "write zero clears", 64'(istat_rd), 64'h00);
      chk("R10", "irq dropped", 64'(irq), 64'h0);

      // fill: extended id, remote frame, short frame
      push_frame(mk(32'h8000_0000 | 32'h1ABC_DEF5, 4'd5, 8'hB2));
      push_frame(mk(32'h4000_0000 | (32'(11'h7FF) << 18), 4'd0, 8'hC3));
      push_frame(mk(32'hC000_0000 | 32'h0000_0001, 4'd15, 8'hD4));
      chk("R11", "full ctrl", 64'(ctrl_rd), 64'h01);
      // R8 overrun: frame dropped, head kept
      push_frame(mk(32'h0000_0042, 4'd3, 8'hE5));
      chk("R8", "overrun flag", 64'(err_rd), 64'h20);
      peek_check("R8");
      // R4 other values do not pop
      host_wr(A_PTR, 8'h01);
      host_wr(A_PTR, 8'h7F);
      peek_check("R4");
      // R3 ordered drain
      for (int k = 0; k < 4; k++) pop_check("R3");
      chk("R5", "drained empty", 64'(ctrl_rd), 64'h81);
      chk("R8", "overrun sticky", 64'(err_rd), 64'h20);
      host_wr(A_ERR, 8'h00);
      chk("R8", "overrun cleared", 64'(err_rd), 64'h00);

      // R6 pop on empty must not move the read pointer
      host_wr(A_PTR, 8'hFF);
      chk("R6", "still empty", 64'(ctrl_rd), 64'h81);
      push_frame(mk(32'h0000_0F0F, 4'd6, 8'h5A));
      peek_check("R6");

      // R7 flush on disable
      push_frame(mk(32'h0000_1234, 4'd1, 8'h66));
      host_wr(A_CTRL, 8'h00); m_en = 0;
      sb.delete(); m_cnt = 0;
      chk("R7", "flushed", 64'(ctrl_rd), 64'h80);
      host_wr(A_CTRL, 8'h01); m_en = 1;
      chk("R7", "empty after re-enable", 64'(ctrl_rd), 64'h81);
      push_frame(mk(32'(11'h055) << 18, 4'd4, 8'h77));
      peek_check("R7");

      // R9 store wins over same-cycle clear
      host_wr(A_ISTAT, 8'h00);
      wr_en = 1'b1; wr_addr = A_ISTAT; wr_data = 8'h00;
      push_frame(mk(32'h8123_4567, 4'd7, 8'h88));
      wr_en = 1'b0;
      chk("R9", "set beats clear", 64'(istat_rd), 64'h10);
      pop_check("R3");
      pop_check("R3");

      // R3 wraparound
      for (int r = 0; r < 6; r++) begin
         for (int j = 0; j < 3; j++)
            push_frame(mk(32'h8000_0000 | 32'(r * 16 + j), 4'(j + 2), 8'(r * 8 + j)));
         for (int j = 0; j < 3; j++) pop_check("R3");
      end
      chk("R5", "final empty", 64'(ctrl_rd), 64'h81);
      chk("R8", "no spurious overrun", 64'(err_rd), 64'h00);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule